// File: doc/BRIEF.md
# Burst-to-APB Transfer Bridge

This block sits between a fast system-side requester and a set of APB peripherals that share one clock with it. The peripheral side advances only on the cycles that an integer-ratio enable strobe marks. The requester hands over one burst at a time: a start address, a beat count, a direction and, for writes, a stream of data words. The bridge replays the burst as a chain of single APB transfers. Each transfer has its own setup and access phase, and the address grows by one 32-bit word per beat.

Write words go into a small FIFO, so the requester can deliver them ahead of the slow peripheral side. Read words come back on a stream, one word per beat and in beat order. A single response pulse closes the burst. It reports failure if any peripheral flagged an error. The remaining beats still run after an error, and a read beat that failed returns zero.

Top module: `burst_apb_bridge`

## Requirements
- R1: Every APB transfer begins with a setup phase (psel=1, penable=0) that lasts until an enabled edge, followed by an access phase (psel=1, penable=1); penable is never high without psel.
- R2: A request with length field L (0..15) produces exactly L+1 APB transfers, after which resp_valid is high for exactly one clock cycle, in the cycle after the last beat completes.
- R3: The first transfer uses req_addr; each later transfer of the burst uses the previous address plus 4.
- R4: pwrite equals req_write (1 = write, 0 = read) for every transfer of a burst and does not change while psel is high.
- R5: The write FIFO holds 8 words; wd_ready is 1 exactly when it is not full; words are accepted in any state and driven onto pwdata in arrival order; a write beat does not enter setup until a word is available.
- R6: For a read burst, rd_valid is high for one cycle after each completing edge, with rd_data carrying that beat's prdata, in beat order.
- R7: If pslverr is high on a completing edge, the burst still runs all its beats, resp_err is 1 with resp_valid, and that read beat's rd_data is 0; the next burst starts with no error.
- R8: psel, penable, paddr, pwrite and pwdata change only at edges where apb_en is 1.
- R9: While pready is 0, the access phase holds with paddr and pwdata unchanged; a beat completes only on an edge with apb_en=1 and pready=1.
- R10: req_ready is 1 only when no burst is in progress; a request presented while busy is ignored and causes no transfer.
- R11: After reset, psel, penable, rd_valid and resp_valid are 0, and req_ready and wd_ready are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| apb_en | input | 1 | Peripheral-side enable strobe |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Bridge idle, request taken |
| req_addr | input | ADDR_W | Burst start byte address |
| req_len | input | LEN_W | Beats minus one |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| wd_valid | input | 1 | Write word present |
| wd_ready | output | 1 | Write FIFO has room |
| wd_data | input | DATA_W | Write word |
| rd_valid | output | 1 | Read word present for one cycle |
| rd_data | output | DATA_W | Read word |
| resp_valid | output | 1 | Burst finished, one-cycle pulse |
| resp_err | output | 1 | Burst had at least one failed beat |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| paddr | output | ADDR_W | APB address |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB slave error |

## Verification
A wrong beat counter shows up at the ports within one burst: either the response pulse arrives after too few or too many APB transfers, or the bridge never returns to idle. A bad address register or FIFO pointer is visible on the first affected transfer, as a paddr or pwdata value that differs from the scoreboard at the completing edge. A stale error flag appears as a resp_err of 1 on the next clean burst. A sequencer that ignores the enable strobe or the ready signal moves psel or paddr on a disabled edge or during a wait state. The bench compares these outputs at the next sample point.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_SETUP,
    ST_ACCESS,
    ST_DONE
  } brg_state_t;
endpackage

// File: rtl/brg_wbuf.sv
module brg_wbuf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [PTR_W:0]    count;

  assign full     = (count == (PTR_W+1)'(DEPTH));
  assign empty    = (count == '0);
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + (PTR_W+1)'(1);
        2'b01:   count <= count - (PTR_W+1)'(1);
        default: count <= count;
      endcase
    end
  end

  // R5: the sequencer never takes a word that is not there
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R5: occupancy never passes the depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    full |=> (count <= (PTR_W+1)'(DEPTH)));
endmodule

// File: rtl/brg_seq.sv
module brg_seq
  import brg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apb_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic              buf_empty,
  input  logic [DATA_W-1:0] buf_data,
  output logic              buf_pop,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              resp_valid,
  output logic              resp_err,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  brg_state_t        state, state_n;
  logic [LEN_W-1:0]  beats_left;
  logic [ADDR_W-1:0] next_addr;
  logic              dir, err_seen;
  logic              beat_done, last_beat, have_data, start_setup;

  always_comb begin
    beat_done   = (state == ST_ACCESS) && apb_en && pready;
    last_beat   = (beats_left == '0);
    have_data   = !dir || !buf_empty;
    start_setup = apb_en && have_data &&
                  ((state == ST_PREP) || (beat_done && !last_beat));
  end

  assign buf_pop    = start_setup && dir;
  assign psel       = (state == ST_SETUP) || (state == ST_ACCESS);
  assign penable    = (state == ST_ACCESS);
  assign req_ready  = (state == ST_IDLE);
  assign resp_valid = (state == ST_DONE);

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:   if (req_valid) state_n = ST_PREP;
      ST_PREP:   if (start_setup) state_n = ST_SETUP;
      ST_SETUP:  if (apb_en) state_n = ST_ACCESS;
      ST_ACCESS: if (beat_done) begin
                   if (last_beat)        state_n = ST_DONE;
                   else if (start_setup) state_n = ST_SETUP;
                   else                  state_n = ST_PREP;
                 end
      ST_DONE:   state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      beats_left <= '0;
      next_addr  <= '0;
      dir        <= 1'b0;
      err_seen   <= 1'b0;
      paddr      <= '0;
      pwrite     <= 1'b0;
      pwdata     <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      resp_err   <= 1'b0;
    end else begin
      state    <= state_n;
      rd_valid <= 1'b0;
      if ((state == ST_IDLE) && req_valid) begin
        next_addr  <= req_addr;
        beats_left <= req_len;
        dir        <= req_write;
        err_seen   <= 1'b0;
      end
      if (start_setup) begin
        paddr  <= beat_done ? (next_addr + STEP) : next_addr;
        pwrite <= dir;
        pwdata <= dir ? buf_data : '0;
      end
      if (beat_done) begin
        next_addr <= next_addr + STEP;
        err_seen  <= err_seen | pslverr;
        if (!last_beat) beats_left <= beats_left - LEN_W'(1);
        else            resp_err   <= err_seen | pslverr;
        if (!dir) begin
          rd_valid <= 1'b1;
          rd_data  <= pslverr ? '0 : prdata;
        end
      end
    end
  end

  // R1: enable only inside a selected transfer, and only after a setup phase
  p_enable_in_sel_r1: assert property (@(posedge clk) disable iff (rst)
    penable |-> psel);
  p_setup_first_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(penable) |-> $past(psel && !penable));
  // R2: the response is a single-cycle pulse
  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  // R4: direction fixed while selected
  p_dir_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (psel && $past(psel)) |-> $stable(pwrite));
  // R8: bus outputs frozen across disabled edges
  p_strobe_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !apb_en |=> ($stable(psel) && $stable(penable) && $stable(paddr) && $stable(pwdata)));
  // R9: wait states hold the access phase
  p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=> (psel && penable && $stable(paddr) && $stable(pwdata)));
  // R6: read words appear only for read transfers
  p_rd_only_reads_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$past(pwrite));
endmodule

// File: rtl/burst_apb_bridge.sv
module burst_apb_bridge #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 4,
  parameter int BUF_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apb_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              resp_valid,
  output logic              resp_err,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);
  logic              buf_full, buf_empty, buf_pop;
  logic [DATA_W-1:0] buf_data;

  assign wd_ready = !buf_full;

  brg_wbuf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (wd_valid && wd_ready),
    .push_data (wd_data),
    .full      (buf_full),
    .pop       (buf_pop),
    .pop_data  (buf_data),
    .empty     (buf_empty)
  );

  brg_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .apb_en     (apb_en),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_write  (req_write),
    .buf_empty  (buf_empty),
    .buf_data   (buf_data),
    .buf_pop    (buf_pop),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .pready     (pready),
    .pslverr    (pslverr)
  );
endmodule

// File: tb/sim_burst_apb_bridge.sv
`timescale 1ns/1ps
module sim_burst_apb_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        apb_en = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic        wd_valid = 1'b0;
  logic [31:0] wd_data = '0;
  logic        req_ready, wd_ready, rd_valid, resp_valid, resp_err;
  logic [31:0] rd_data;
  logic        psel, penable, pwrite;
  logic [31:0] paddr, pwdata;
  logic [31:0] prdata = '0;
  logic        pready = 1'b0, pslverr = 1'b0;

  always #10 clk = ~clk;

  burst_apb_bridge u0 (
    .clk(clk), .rst(rst), .apb_en(apb_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .resp_valid(resp_valid), .resp_err(resp_err),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  int checks = 0, errors = 0;
  int ratio = 1, ws_cfg = 0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  bit finished = 0;

  logic [31:0] exp_addr[$], exp_wd[$], exp_rd[$];
  bit          exp_wr[$], exp_resp[$];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hC3C3_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- monitor + peripheral model ----------------
  int en_cnt = 0, ws_left = 0, cyc = 0;
  bit prev_en = 0, seen_setup = 0, hold_pend = 0;
  logic [31:0] held_addr;
  logic        s_psel, s_pen, s_pwr;
  logic [31:0] s_addr, s_wd;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst) begin
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(0, "R6 unexpected rd_valid", rd_data, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_rd.pop_front();
          chk(rd_data == e, "R6/R7 rd_data", rd_data, e);
        end
      end
      if (resp_valid) begin
        if (exp_resp.size() == 0) chk(0, "R2 unexpected resp_valid", 32'h1, 32'h0);
        else begin
          bit e;
          e = exp_resp.pop_front();
          chk(resp_err == e, "R7 resp_err", {31'h0, resp_err}, {31'h0, e});
        end
      end
      if (!prev_en)
        chk(psel == s_psel && penable == s_pen && paddr == s_addr && pwrite == s_pwr && pwdata == s_wd,
            "R8 bus moved on disabled edge", paddr, s_addr);
      if (hold_pend) begin
        chk(psel && penable && paddr == held_addr, "R9 access not held", paddr, held_addr);
        hold_pend = 0;
      end
    end
    s_psel = psel; s_pen = penable; s_addr = paddr; s_pwr = pwrite; s_wd = pwdata;

    apb_en = (en_cnt == 0);
    en_cnt = (en_cnt + 1 >= ratio) ? 0 : en_cnt + 1;

    if (psel && !penable) begin
      ws_left = ws_cfg;
      seen_setup = 1;
    end
    pready  = psel && penable && (ws_left == 0);
    pslverr = psel && penable && (paddr == err_addr);
    prdata  = pat(paddr);
    if (psel && penable && ws_left > 0 && apb_en) ws_left--;
    if (!rst && psel && penable && !pready) begin
      hold_pend = 1;
      held_addr = paddr;
    end

    if (!rst && psel && penable && pready && apb_en) begin
      chk(seen_setup, "R1 no setup before access", {31'h0, seen_setup}, 32'h1);
      seen_setup = 0;
      if (exp_addr.size() == 0) chk(0, "R2 extra transfer", paddr, 32'h0);
      else begin
        logic [31:0] ea, ew;
        bit er;
        ea = exp_addr.pop_front(); er = exp_wr.pop_front(); ew = exp_wd.pop_front();
        chk(paddr == ea, "R3 paddr", paddr, ea);
        chk(pwrite == er, "R4 pwrite", {31'h0, pwrite}, {31'h0, er});
        if (er) chk(pwdata == ew, "R5 pwdata order", pwdata, ew);
      end
    end
    prev_en = rst ? 1'b1 : apb_en;
  end

  // ---------------- driver ----------------
  task automatic push_word(input logic [31:0] d);
    bit taken;
    wd_valid = 1'b1;
    wd_data  = d;
    do begin
      taken = wd_ready;
      @(negedge clk);
    end while (!taken);
    wd_valid = 1'b0;
  endtask

  task automatic issue(input logic [31:0] a, input int n, input bit wr, input logic [31:0] base);
    bit any_err = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] ai;
      ai = a + 32'(4 * i);
      exp_addr.push_back(ai);
      exp_wr.push_back(wr);
      exp_wd.push_back(base + 32'(i));
      if (ai == err_addr) any_err = 1;
      if (!wr) exp_rd.push_back((ai == err_addr) ? 32'h0 : pat(ai));
    end
    exp_resp.push_back(any_err);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = 4'(n - 1); req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_resp.size() != 0 || exp_addr.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!psel && !penable, "R11 psel/penable after reset", {30'h0, psel, penable}, 32'h0);
    chk(req_ready && wd_ready, "R11 ready after reset", {30'h0, req_ready, wd_ready}, 32'h3);
    chk(!rd_valid && !resp_valid, "R11 valids after reset", {30'h0, rd_valid, resp_valid}, 32'h0);

    // write of 3 beats, data fed after request (R2 R3 R4 R5)
    ratio = 1; ws_cfg = 0;
    issue(32'h0000_0100, 3, 1'b1, 32'hA000_0000);
    for (int i = 0; i < 3; i++) push_word(32'hA000_0000 + 32'(i));
    wait_done();

    // read of 4 beats with wait states (R6 R9)
    ratio = 2; ws_cfg = 2;
    issue(32'h0000_2000, 4, 1'b0, 32'h0);
    wait_done();

    // read of 5 with an error on beat 3, poke while busy (R7 R10)
    ratio = 3; ws_cfg = 1; err_addr = 32'h0000_3008;
    issue(32'h0000_3000, 5, 1'b0, 32'h0);
    for (int i = 0; i < 8; i++) begin
      req_valid = 1'b1; req_addr = 32'h0000_9000; req_len = 4'd3; req_write = 1'b0;
      chk(!req_ready, "R10 req_ready while busy", {31'h0, req_ready}, 32'h0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_done();
    err_addr = 32'hFFFF_FFF0;

    // buffer full then 16-beat write (R5 R2)
    ratio = 2; ws_cfg = 0;
    for (int i = 0; i < 8; i++) push_word(32'hB000_0000 + 32'(i));
    chk(!wd_ready, "R5 wd_ready low when 8 held", {31'h0, wd_ready}, 32'h0);
    issue(32'h0000_4000, 16, 1'b1, 32'hB000_0000);
    for (int i = 8; i < 16; i++) push_word(32'hB000_0000 + 32'(i));
    wait_done();
    chk(wd_ready, "R5 wd_ready after drain", {31'h0, wd_ready}, 32'h1);

    // single-beat read (R2 minimum length)
    ratio = 1; ws_cfg = 0;
    issue(32'h0000_5FFC, 1, 1'b0, 32'h0);
    wait_done();

    // write with error on second beat (R7)
    err_addr = 32'h0000_6004;
    issue(32'h0000_6000, 2, 1'b1, 32'hC000_0000);
    push_word(32'hC000_0000);
    push_word(32'hC000_0001);
    wait_done();
    err_addr = 32'hFFFF_FFF0;

    // clean burst after error clears the flag (R7)
    ratio = 3; ws_cfg = 1;
    issue(32'h0000_7000, 2, 1'b0, 32'h0);
    wait_done();

    repeat (10) @(negedge clk);
    chk(exp_addr.size() == 0 && exp_rd.size() == 0 && exp_resp.size() == 0,
        "R2 all expected transfers seen", 32'(exp_addr.size()), 32'h0);
    chk(!psel && req_ready, "R2 idle at end", {30'h0, psel, req_ready}, 32'h1);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule